// File: doc/BRIEF.md
# Card Controller Status and Register Front End

This block is the register front end of a memory-card host controller. It sits between a simple word-addressed request port and the controller's command and data engines. The engines report events as one-cycle set pulses. The front end latches those events in a sticky status word and merges them with level status bits that describe the FIFO. Two interrupt lines are formed by masking that word, and software clears events by writing ones.

The block does not move data. It turns software accesses to the FIFO data window into pop and push strobes toward the data FIFO, and it reports the remaining transfer length in whole words. It also returns a fixed eight-byte identification pattern near the top of the window.

A pacing rule protects slow drivers. Each successful FIFO word read raises a hold line that stalls the data engine. The hold stays up until software next reads either the status word or the word-count register. Read data is registered: it appears on `rdata_o` on the cycle after the request, and it stays there until the next read.

Top module: `mmc_reg_frontend`

## Requirements
- R1: After reset, the power and clock registers, both masks, the sticky status bits and the hold flag are zero. Both interrupt lines are low and `rdata_o` is zero.
- R2: Reading offset 0x034 returns status. Bits 10:0 are sticky and are set by `evt_set_i` pulses. Bits 21:11 follow `fifo_live_i` directly, and bits 31:22 read zero.
- R3: A write to offset 0x038 clears each sticky bit whose data bit is one. Only data bits 10:0 act, and the upper bits have no effect. When an event pulse and a clear hit the same bit in the same cycle, the event wins.
- R4: `irq_o[k]` is high exactly when the status word ANDed with mask k is nonzero. Mask 0 is at offset 0x03C and mask 1 at 0x040, and both are full 32-bit read/write registers.
- R5: Reading offset 0x048 returns the byte count rounded up to whole words, (`byte_cnt_i`+3)>>2, computed without overflow.
- R6: A read in the FIFO window 0x080 to 0x0BC while the FIFO holds data does three things. It pulses `fifo_pop_o` in the request cycle, returns `fifo_rdata_i`, and sets `hold_o` from the next cycle.
- R7: A FIFO-window read while `fifo_empty_i` is high returns zero, gives no pop, pulses `fifo_err_o` for one cycle and leaves `hold_o` unchanged.
- R8: A read of status (0x034) or word count (0x048) returns the value from before the access. It then clears `hold_o` from the next cycle.
- R9: A FIFO-window write while `byte_cnt_i` is nonzero pulses `fifo_push_o`, with `fifo_wdata_o` equal to the written word. While `byte_cnt_i` is zero the write gives no push and pulses `fifo_err_o`.
- R10: Reads at 0xFE0, 0xFE4 and so on up to 0xFFC return the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended.
- R11: Power (0x000) and clock (0x004) keep only data bits 7:0. They read back zero-extended and drive `power_o` and `clk_ctrl_o`.
- R12: Any other access is rejected. This covers undefined offsets, a non-word-aligned address, a write to a read-only offset and a read of the clear offset. A rejected access changes no state, loads zero into `rdata_o` and raises `bad_addr_o` for the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address within the window |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| bad_addr_o | output | 1 | Rejected-access pulse |
| evt_set_i | input | 11 | Event set pulses for sticky status bits 10:0 |
| fifo_live_i | input | 11 | Level status for bits 21:11 |
| byte_cnt_i | input | 16 | Remaining transfer bytes |
| fifo_empty_i | input | 1 | Data FIFO empty |
| fifo_rdata_i | input | 32 | FIFO head word |
| fifo_pop_o | output | 1 | Pop FIFO head |
| fifo_push_o | output | 1 | Push word into FIFO |
| fifo_wdata_o | output | 32 | Word to push |
| fifo_err_o | output | 1 | Empty-read or zero-count-write pulse |
| hold_o | output | 1 | Stall the data engine |
| power_o | output | 8 | Power control register |
| clk_ctrl_o | output | 8 | Clock control register |
| irq_o | output | 2 | Masked interrupt lines |

## Verification
The bench goes after the cycles where two effects meet.

A clear and an event pulse can hit the same bit in one cycle. A design that gave the clear priority would lose that event.

A status read also clears the hold. If the read returned the value from after the update, software would see data it never acknowledged. An empty-FIFO read must leave the hold alone; clearing or setting it there would break the pacing.

Word-count rounding at 0, 1, 4, 5 and 0xFFFF catches a truncating or overflowing adder. Writes to read-only offsets and misaligned writes must leave state untouched, or a stray store would corrupt status or power.

// File: rtl/mmc_regs_pkg.sv
`timescale 1ns/1ps
package mmc_regs_pkg;
  localparam int ADDR_W  = 12;
  localparam int NUM_IRQ = 2;

  localparam logic [ADDR_W-1:0] OFF_POWER     = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CLOCK     = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_STATUS    = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_CLEAR     = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_MASK_BASE = 12'h03C;
  localparam logic [ADDR_W-1:0] OFF_FCNT      = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_FIFO_LO   = 12'h080;
  localparam logic [ADDR_W-1:0] OFF_FIFO_HI   = 12'h0BC;
  localparam logic [ADDR_W-1:0] OFF_ID_LO     = 12'hFE0;

  typedef struct packed {
    logic               power;
    logic               clock;
    logic               status;
    logic               clear;
    logic [NUM_IRQ-1:0] mask;
    logic               fcnt;
    logic               fifo;
    logic               id;
    logic               bad;
  } hit_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/mmc_reg_decode.sv
`timescale 1ns/1ps
module mmc_reg_decode
  import mmc_regs_pkg::*;
(
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o
);
  logic aligned;
  logic any_hit;

  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    hit_o = '0;
    if (valid_i && aligned) begin
      hit_o.power  = (addr_i == OFF_POWER);
      hit_o.clock  = (addr_i == OFF_CLOCK);
      hit_o.status = (addr_i == OFF_STATUS) && !we_i;
      hit_o.clear  = (addr_i == OFF_CLEAR) && we_i;
      hit_o.fcnt   = (addr_i == OFF_FCNT) && !we_i;
      hit_o.fifo   = (addr_i >= OFF_FIFO_LO) && (addr_i <= OFF_FIFO_HI);
      hit_o.id     = (addr_i >= OFF_ID_LO) && !we_i;
      for (int k = 0; k < NUM_IRQ; k++)
        hit_o.mask[k] = (addr_i == OFF_MASK_BASE + ADDR_W'(4 * k));
    end
    any_hit = hit_o.power | hit_o.clock | hit_o.status | hit_o.clear |
              (|hit_o.mask) | hit_o.fcnt | hit_o.fifo | hit_o.id;
    hit_o.bad = valid_i && !any_hit;
  end
endmodule

// File: rtl/mmc_status_irq.sv
`timescale 1ns/1ps
module mmc_status_irq #(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 22,
  parameter int STICKY_W = 11,
  parameter int NUM_IRQ  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [STICKY_W-1:0]             set_i,
  input  logic [STAT_W-STICKY_W-1:0]      live_i,
  input  logic                            clr_en_i,
  input  logic [STICKY_W-1:0]             clr_bits_i,
  input  logic [NUM_IRQ-1:0]              mask_we_i,
  input  logic [DATA_W-1:0]               mask_wdata_i,
  output logic [DATA_W-1:0]               status_o,
  output logic [NUM_IRQ-1:0][DATA_W-1:0]  mask_o,
  output logic [NUM_IRQ-1:0]              irq_o
);
  logic [STICKY_W-1:0]            sticky_q;
  logic [NUM_IRQ-1:0][DATA_W-1:0] mask_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sticky_q <= '0;
    else if (clr_en_i) sticky_q <= (sticky_q & ~clr_bits_i) | set_i;
    else               sticky_q <= sticky_q | set_i;
  end

  assign status_o = DATA_W'({live_i, sticky_q});

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           mask_q[k] <= '0;
      else if (mask_we_i[k]) mask_q[k] <= mask_wdata_i;
    end
    assign irq_o[k] = |(status_o & mask_q[k]);
  end

  assign mask_o = mask_q;

  // R2
  sticky_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |=> (($past(sticky_q) & ~sticky_q) == '0));
  // R2
  set_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sticky_q & $past(set_i)) == $past(set_i)));
  // R3
  clear_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((sticky_q & $past(clr_bits_i & ~set_i)) == '0));
endmodule

// File: rtl/mmc_fifo_gate.sv
`timescale 1ns/1ps
module mmc_fifo_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_rd_i,
  input  logic fifo_wr_i,
  input  logic hold_clr_i,
  input  logic fifo_empty_i,
  input  logic cnt_zero_i,
  output logic pop_o,
  output logic push_o,
  output logic err_o,
  output logic hold_o
);
  logic hold_q, err_q;

  assign pop_o  = fifo_rd_i && !fifo_empty_i;
  assign push_o = fifo_wr_i && !cnt_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= (fifo_rd_i && fifo_empty_i) || (fifo_wr_i && cnt_zero_i);
      if (pop_o)           hold_q <= 1'b1;
      else if (hold_clr_i) hold_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;
  assign err_o  = err_q;

  // R6
  pop_sets_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> hold_q);
  // R8
  ack_clears_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_clr_i && !fifo_rd_i) |=> !hold_q);
  // R7
  empty_read_keeps_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_i && fifo_empty_i && !hold_clr_i) |=> (hold_q == $past(hold_q)));
  // R9
  zero_cnt_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_i && cnt_zero_i) |=> err_q);
endmodule

// File: rtl/mmc_reg_frontend.sv
`timescale 1ns/1ps
module mmc_reg_frontend
  import mmc_regs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 22,
  parameter int STICKY_W = 11,
  parameter int CNT_W    = 16,
  parameter int CTRL_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       req_we_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [DATA_W-1:0]          req_wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       bad_addr_o,
  input  logic [STICKY_W-1:0]        evt_set_i,
  input  logic [STAT_W-STICKY_W-1:0] fifo_live_i,
  input  logic [CNT_W-1:0]           byte_cnt_i,
  input  logic                       fifo_empty_i,
  input  logic [DATA_W-1:0]          fifo_rdata_i,
  output logic                       fifo_pop_o,
  output logic                       fifo_push_o,
  output logic [DATA_W-1:0]          fifo_wdata_o,
  output logic                       fifo_err_o,
  output logic                       hold_o,
  output logic [CTRL_W-1:0]          power_o,
  output logic [CTRL_W-1:0]          clk_ctrl_o,
  output logic [NUM_IRQ-1:0]         irq_o
);
  localparam int WCNT_W = CNT_W + 1;

  hit_t                           hit;
  logic [CTRL_W-1:0]              power_q, clk_q;
  logic [DATA_W-1:0]              rdata_q, rd_mux, status_w;
  logic [NUM_IRQ-1:0][DATA_W-1:0] mask_w;
  logic [NUM_IRQ-1:0]             mask_we;
  logic [WCNT_W-1:0]              word_cnt;
  logic                           bad_q;

  mmc_reg_decode u_decode (
    .valid_i (req_valid_i),
    .we_i    (req_we_i),
    .addr_i  (req_addr_i),
    .hit_o   (hit)
  );

  assign mask_we = req_we_i ? hit.mask : '0;

  mmc_status_irq #(
    .DATA_W   (DATA_W),
    .STAT_W   (STAT_W),
    .STICKY_W (STICKY_W),
    .NUM_IRQ  (NUM_IRQ)
  ) u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (evt_set_i),
    .live_i       (fifo_live_i),
    .clr_en_i     (hit.clear),
    .clr_bits_i   (req_wdata_i[STICKY_W-1:0]),
    .mask_we_i    (mask_we),
    .mask_wdata_i (req_wdata_i),
    .status_o     (status_w),
    .mask_o       (mask_w),
    .irq_o        (irq_o)
  );

  mmc_fifo_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_rd_i    (hit.fifo && !req_we_i),
    .fifo_wr_i    (hit.fifo && req_we_i),
    .hold_clr_i   (hit.status || hit.fcnt),
    .fifo_empty_i (fifo_empty_i),
    .cnt_zero_i   (byte_cnt_i == '0),
    .pop_o        (fifo_pop_o),
    .push_o       (fifo_push_o),
    .err_o        (fifo_err_o),
    .hold_o       (hold_o)
  );

  assign fifo_wdata_o = req_wdata_i;
  assign word_cnt     = (WCNT_W'(byte_cnt_i) + WCNT_W'(3)) >> 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      power_q <= '0;
      clk_q   <= '0;
    end else if (req_we_i) begin
      if (hit.power) power_q <= req_wdata_i[CTRL_W-1:0];
      if (hit.clock) clk_q   <= req_wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit.power)  rd_mux = DATA_W'(power_q);
    if (hit.clock)  rd_mux = DATA_W'(clk_q);
    if (hit.status) rd_mux = status_w;
    if (hit.fcnt)   rd_mux = DATA_W'(word_cnt);
    if (hit.id)     rd_mux = DATA_W'(id_byte(req_addr_i[4:2]));
    if (hit.fifo && !fifo_empty_i) rd_mux = fifo_rdata_i;
    for (int k = 0; k < NUM_IRQ; k++)
      if (hit.mask[k]) rd_mux = mask_w[k];
  end

  // status value is captured before the same-edge update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= hit.bad;
      if (req_valid_i && (!req_we_i || hit.bad)) rdata_q <= rd_mux;
    end
  end

  assign rdata_o    = rdata_q;
  assign bad_addr_o = bad_q;
  assign power_o    = power_q;
  assign clk_ctrl_o = clk_q;

  // R12
  bad_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr_o |-> (rdata_o == '0));
  // R12
  bad_keeps_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr_o |-> ($stable(power_q) && $stable(clk_q)));
  // R12
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit.power, hit.clock, hit.status, hit.clear, hit.mask,
              hit.fcnt, hit.fifo, hit.id, hit.bad}));
  // R11
  ctrl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit.power && req_we_i) |=> (power_o == $past(req_wdata_i[CTRL_W-1:0])));
endmodule

// File: tb/mmc_reg_frontend_tb_top.sv
`timescale 1ns/1ps
module mmc_reg_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [11:0] req_addr;
  logic [31:0] req_wdata, rdata, fifo_rdata, fifo_wdata;
  logic        bad_addr, fifo_empty, fifo_pop, fifo_push, fifo_err, hold;
  logic [10:0] evt_set, fifo_live;
  logic [15:0] byte_cnt;
  logic [7:0]  power, clk_ctrl;
  logic [1:0]  irq;

  int unsigned vec = 0, mis = 0;
  bit          done = 0;

  logic [10:0]      sticky_m, live_m;
  logic [1:0][31:0] mask_m;
  logic             c_pop, c_push;
  logic [31:0]      c_wdata;

  always #10 clk = ~clk;

  mmc_reg_frontend dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rdata_o(rdata), .bad_addr_o(bad_addr),
    .evt_set_i(evt_set), .fifo_live_i(fifo_live), .byte_cnt_i(byte_cnt),
    .fifo_empty_i(fifo_empty), .fifo_rdata_i(fifo_rdata),
    .fifo_pop_o(fifo_pop), .fifo_push_o(fifo_push), .fifo_wdata_o(fifo_wdata),
    .fifo_err_o(fifo_err), .hold_o(hold), .power_o(power),
    .clk_ctrl_o(clk_ctrl), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {10'b0, live_m, sticky_m};
  endfunction

  function automatic logic [31:0] exp_irq();
    logic [31:0] r = '0;
    for (int k = 0; k < 2; k++) r[k] = |(exp_status() & mask_m[k]);
    return r;
  endfunction

  function automatic logic [31:0] exp_words(input logic [15:0] c);
    logic [16:0] s = {1'b0, c} + 17'd3;
    return 32'(s >> 2);
  endfunction

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  // drive at a falling edge, return at the next falling edge
  task automatic acc(input logic v, input logic we, input logic [11:0] a,
                     input logic [31:0] d, input logic [10:0] s);
    req_valid = v; req_we = we; req_addr = a; req_wdata = d; evt_set = s;
    #1;
    c_pop = fifo_pop; c_push = fifo_push; c_wdata = fifo_wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; evt_set = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      mis++; vec++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e;
    logic [10:0] s;
    logic [15:0] c;
    int k;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    evt_set = '0; fifo_live = '0; byte_cnt = '0; fifo_empty = 1'b1; fifo_rdata = '0;
    sticky_m = '0; live_m = '0; mask_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", {30'b0, irq}, 32'h0);
    chk("R1 hold", {31'b0, hold}, 32'h0);
    chk("R1 power", {24'b0, power}, 32'h0);
    acc(1, 0, 12'h03C, 0, 0); chk("R1 mask0", rdata, 32'h0);
    acc(1, 0, 12'h040, 0, 0); chk("R1 mask1", rdata, 32'h0);
    acc(1, 0, 12'h034, 0, 0); chk("R1 status", rdata, 32'h0);

    // R11 power and clock keep 8 bits
    acc(1, 1, 12'h000, 32'h0000_01A5, 0);
    chk("R11 power_o", {24'b0, power}, 32'hA5);
    acc(1, 0, 12'h000, 0, 0); chk("R11 power read", rdata, 32'hA5);
    acc(1, 1, 12'h004, 32'hFFFF_FF3C, 0);
    acc(1, 0, 12'h004, 0, 0); chk("R11 clock read", rdata, 32'h3C);
    chk("R11 clk_ctrl_o", {24'b0, clk_ctrl}, 32'h3C);

    // R4 directed
    acc(1, 1, 12'h03C, 32'h0000_0008, 0); mask_m[0] = 32'h8;
    acc(1, 1, 12'h040, 32'h0000_8000, 0); mask_m[1] = 32'h8000;
    acc(0, 0, 0, 0, 11'h008); sticky_m = 11'h008;
    chk("R4 irq sticky", {30'b0, irq}, 32'h1);
    fifo_live = 11'h010; live_m = 11'h010; #1;
    chk("R4 irq live", {30'b0, irq}, 32'h3);

    // R3 set beats clear, upper clear bits ignored
    acc(1, 1, 12'h038, 32'hFFFF_F828, 11'h020);
    sticky_m = 11'h020;
    acc(1, 0, 12'h034, 0, 0);
    chk("R3 set over clear", rdata, exp_status());
    chk("R4 irq after clear", {30'b0, irq}, exp_irq());

    // R5 rounding boundaries
    foreach (byte_cnt[i]) ;
    for (int i = 0; i < 5; i++) begin
      c = (i == 0) ? 16'd0 : (i == 1) ? 16'd1 : (i == 2) ? 16'd4 : (i == 3) ? 16'd5 : 16'hFFFF;
      byte_cnt = c;
      acc(1, 0, 12'h048, 0, 0);
      chk("R5 word count", rdata, exp_words(c));
    end

    // R6 pop, R8 status read clears hold
    fifo_empty = 1'b0; fifo_rdata = 32'hCAFE_F00D;
    acc(1, 0, 12'h084, 0, 0);
    chk("R6 pop", {31'b0, c_pop}, 32'h1);
    chk("R6 data", rdata, 32'hCAFE_F00D);
    chk("R6 hold", {31'b0, hold}, 32'h1);
    // R7 empty read
    fifo_empty = 1'b1;
    acc(1, 0, 12'h080, 0, 0);
    chk("R7 data", rdata, 32'h0);
    chk("R7 pop", {31'b0, c_pop}, 32'h0);
    chk("R7 err", {31'b0, fifo_err}, 32'h1);
    chk("R7 hold kept", {31'b0, hold}, 32'h1);
    acc(0, 0, 0, 0, 0);
    chk("R7 err one cycle", {31'b0, fifo_err}, 32'h0);
    e = exp_status();
    acc(1, 0, 12'h034, 0, 11'h001);
    sticky_m |= 11'h001;
    chk("R8 pre-read status", rdata, e);
    chk("R8 hold cleared", {31'b0, hold}, 32'h0);
    fifo_empty = 1'b0;
    acc(1, 0, 12'h0BC, 0, 0);
    chk("R6 hold again", {31'b0, hold}, 32'h1);
    byte_cnt = 16'd9;
    acc(1, 0, 12'h048, 0, 0);
    chk("R8 count read", rdata, 32'd3);
    chk("R8 hold cleared by count", {31'b0, hold}, 32'h0);
    fifo_empty = 1'b1;

    // R9 FIFO writes
    byte_cnt = 16'd0;
    acc(1, 1, 12'h0BC, 32'h1111_2222, 0);
    chk("R9 no push at zero", {31'b0, c_push}, 32'h0);
    chk("R9 err at zero", {31'b0, fifo_err}, 32'h1);
    byte_cnt = 16'd7;
    acc(1, 1, 12'h090, 32'h1234_5678, 0);
    chk("R9 push", {31'b0, c_push}, 32'h1);
    chk("R9 wdata", c_wdata, 32'h1234_5678);
    chk("R9 no err", {31'b0, fifo_err}, 32'h0);

    // R10 identification bytes
    for (int i = 0; i < 8; i++) begin
      acc(1, 0, 12'hFE0 + 12'(4 * i), 0, 0);
      chk("R10 id byte", rdata, {24'b0, exp_id(i)});
    end

    // R12 rejected accesses
    acc(1, 0, 12'h000, 0, 0);
    acc(1, 0, 12'h044, 0, 0);
    chk("R12 undefined read data", rdata, 32'h0);
    chk("R12 bad pulse", {31'b0, bad_addr}, 32'h1);
    acc(0, 0, 0, 0, 0);
    chk("R12 bad one cycle", {31'b0, bad_addr}, 32'h0);
    acc(1, 1, 12'h034, 32'hFFFF_FFFF, 0);
    chk("R12 status write bad", {31'b0, bad_addr}, 32'h1);
    acc(1, 0, 12'h034, 0, 0);
    chk("R12 status unchanged", rdata, exp_status());
    acc(1, 0, 12'h038, 0, 0);
    chk("R12 clear read bad", {31'b0, bad_addr}, 32'h1);
    acc(1, 1, 12'h001, 32'h77, 0);
    chk("R12 misaligned bad", {31'b0, bad_addr}, 32'h1);
    chk("R12 power unchanged", {24'b0, power}, 32'hA5);
    acc(1, 0, 12'h0C0, 0, 0);
    chk("R12 past fifo window", {31'b0, bad_addr}, 32'h1);
    acc(1, 1, 12'hFE0, 32'h55, 0);
    chk("R12 id write bad", {31'b0, bad_addr}, 32'h1);

    // random mix for R2 R3 R4 R5
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 5))
        0: begin
          s = 11'($urandom & $urandom);
          acc(0, 0, 0, 0, s); sticky_m |= s;
        end
        1: begin
          d = $urandom; s = 11'($urandom & $urandom & $urandom);
          acc(1, 1, 12'h038, d, s);
          sticky_m = (sticky_m & ~d[10:0]) | s;
        end
        2: begin
          k = $urandom_range(0, 1); d = $urandom & $urandom & $urandom;
          acc(1, 1, 12'h03C + 12'(4 * k), d, 0); mask_m[k] = d;
        end
        3: begin
          e = exp_status();
          acc(1, 0, 12'h034, 0, 0);
          chk("R2 status read", rdata, e);
        end
        4: begin
          live_m = 11'($urandom); fifo_live = live_m; #1;
        end
        default: begin
          c = 16'($urandom);
          byte_cnt = c;
          acc(1, 0, 12'h048, 0, 0);
          chk("R5 random count", rdata, exp_words(c));
        end
      endcase
      chk("R4 irq", {30'b0, irq}, exp_irq());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule